// File: doc/BRIEF.md
# Programmable Flag Offset Register Port

This block keeps the two threshold values that a FIFO's programmable almost-empty and almost-full flags compare against. It also gives software-free access to them through the FIFO's own data pins. A low config-select input turns the normal write and read strobes into offset accesses. A write strobe stores the low bits of the write data into the next offset register. A read strobe shows the next offset register on the read data output. The two registers are always visited in a fixed order: the empty threshold first, then the full threshold.

The write side and the read side each keep their own position in that order. A pause in a sequence, or normal FIFO traffic in between, does not lose the position. When the FIFO runs in fall-through mode, offset readback is blocked. The block also gates the FIFO's storage write and read strobes, so that no data word moves while config-select is low. Both threshold values are driven out continuously for the flag logic.

Top module: `ofs_regs`

## Requirements
- R1: While rst_n is low, empty_ofs equals EMPTY_DEF, full_ofs equals FULL_DEF and rd_data is all zeros. After reset, the first offset write goes to empty_ofs and the first readback shows empty_ofs.
- R2: At a wr_clk rising edge with cfg_n and wr_en_n both low, wr_data[OW-1:0] is stored into the register the write position selects. Position 0 is empty_ofs and position 1 is full_ofs. The position then advances.
- R3: The write position wraps from full_ofs back to empty_ofs, so a third offset write overwrites empty_ofs.
- R4: At a wr_clk edge with cfg_n high, neither offset register changes, whatever wr_en_n and wr_data are.
- R5: Raising cfg_n, or holding wr_en_n or rd_en_n high, between offset accesses keeps the write and read positions. The next access continues the order instead of restarting it.
- R6: At a rd_clk rising edge with cfg_n low, rd_en_n low and ft_mode low, rd_data becomes {zeros, offset}. The offset is empty_ofs at read position 0 and full_ofs at read position 1. The read position then toggles, wrapping from full back to empty.
- R7: With ft_mode high, a rd_clk edge with cfg_n and rd_en_n low leaves rd_data unchanged and does not advance the read position.
- R8: fifo_we is high exactly when cfg_n is high and wr_en_n is low. fifo_re is high exactly when cfg_n is high and rd_en_n is low.
- R9: At a rd_clk edge with fifo_re high, rd_data loads fifo_q. With neither a readback nor fifo_re, rd_data holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_n | input | 1 | Offset access select, active low |
| wr_en_n | input | 1 | Write strobe, active low |
| rd_en_n | input | 1 | Read strobe, active low |
| ft_mode | input | 1 | 1 = fall-through mode, 0 = standard mode |
| wr_data | input | DW | Write data; the low OW bits are offset values |
| fifo_q | input | DW | Data word from FIFO storage |
| rd_data | output | DW | Registered read data |
| empty_ofs | output | OW | Almost-empty threshold |
| full_ofs | output | OW | Almost-full threshold |
| fifo_we | output | 1 | Storage write strobe |
| fifo_re | output | 1 | Storage read strobe |

## Verification
Several properties are checked on every clock edge. The thresholds stay constant while cfg_n is high. An offset write lands in empty_ofs from position 0. A standard-mode readback puts the selected threshold, zero-extended, on rd_data. The read position never moves in fall-through mode. The bench scenarios are needed to show the rest: the order is kept across pauses and interleaved FIFO traffic, the wrap on both sides, and the reset defaults. They also show that a blocked fall-through readback leaves the next standard readback starting where it stopped.

// File: rtl/ofs_regs.sv
module ofs_regs #(
  parameter int DW = 18,
  parameter int OW = 12,
  parameter int unsigned EMPTY_DEF = 127,
  parameter int unsigned FULL_DEF = 127
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          cfg_n,
  input  logic          wr_en_n,
  input  logic          rd_en_n,
  input  logic          ft_mode,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] fifo_q,
  output logic [DW-1:0] rd_data,
  output logic [OW-1:0] empty_ofs,
  output logic [OW-1:0] full_ofs,
  output logic          fifo_we,
  output logic          fifo_re
);
  localparam int PAD = DW - OW;

  logic wsel, rsel;
  logic ld_wr, ld_rd;

  assign ld_wr   = !cfg_n && !wr_en_n;
  assign ld_rd   = !cfg_n && !rd_en_n && !ft_mode;
  assign fifo_we = cfg_n && !wr_en_n;
  assign fifo_re = cfg_n && !rd_en_n;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_ofs <= EMPTY_DEF[OW-1:0];
      full_ofs  <= FULL_DEF[OW-1:0];
      wsel      <= 1'b0;
    end else if (ld_wr) begin
      if (wsel) full_ofs <= wr_data[OW-1:0];
      else      empty_ofs <= wr_data[OW-1:0];
      wsel <= ~wsel;
    end
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
      rsel    <= 1'b0;
    end else if (ld_rd) begin
      rd_data <= {{PAD{1'b0}}, (rsel ? full_ofs : empty_ofs)};
      rsel    <= ~rsel;
    end else if (fifo_re) begin
      rd_data <= fifo_q;
    end
  end

  assert_hold_ofs_R4: assert property (@(posedge wr_clk) disable iff (!rst_n)
    cfg_n |=> ($stable(empty_ofs) && $stable(full_ofs)));

  assert_first_slot_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!cfg_n && !wr_en_n && !wsel) |=> (empty_ofs == $past(wr_data[OW-1:0])));

  assert_readback_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!cfg_n && !rd_en_n && !ft_mode) |=>
      (rd_data == {{PAD{1'b0}}, ($past(rsel) ? $past(full_ofs) : $past(empty_ofs))}));

  assert_ft_block_R7: assert property (@(posedge rd_clk) disable iff (!rst_n)
    ft_mode |=> $stable(rsel));
endmodule

// File: tb/ofs_regs_test.sv
module ofs_regs_test;
  localparam int DW = 18;
  localparam int OW = 12;

  logic wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic cfg_n = 1, wr_en_n = 1, rd_en_n = 1, ft_mode = 0;
  logic [DW-1:0] wr_data = '0, fifo_q = '0;
  logic [DW-1:0] rd_data;
  logic [OW-1:0] empty_ofs, full_ofs;
  logic fifo_we, fifo_re;

  int checks = 0, errors = 0;
  logic [OW-1:0] m_e, m_f;
  logic m_wp, m_rp;
  logic [DW-1:0] m_rd;

  always #5 wr_clk = ~wr_clk;
  initial begin #3; forever #5 rd_clk = ~rd_clk; end

  ofs_regs uut (.*);

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] exp_rd(logic c, logic ren, logic ft, logic rp,
      logic [OW-1:0] e, logic [OW-1:0] f, logic [DW-1:0] q, logic [DW-1:0] old);
    if (!c && !ren && !ft) return {{(DW-OW){1'b0}}, (rp ? f : e)};
    if (c && !ren) return q;
    return old;
  endfunction

  task automatic wcyc(logic c, logic wen, logic [DW-1:0] d, string req);
    @(negedge wr_clk);
    cfg_n = c; wr_en_n = wen; wr_data = d;
    #1 chk("R8", {17'b0, fifo_we}, {17'b0, (c && !wen)});
    @(negedge wr_clk);
    if (!c && !wen) begin
      if (m_wp) m_f = d[OW-1:0]; else m_e = d[OW-1:0];
      m_wp = ~m_wp;
    end
    cfg_n = 1; wr_en_n = 1;
    chk(req, {6'b0, empty_ofs}, {6'b0, m_e});
    chk(req, {6'b0, full_ofs}, {6'b0, m_f});
  endtask

  task automatic rcyc(logic c, logic ren, logic ft, logic [DW-1:0] q, string req);
    @(negedge rd_clk);
    cfg_n = c; rd_en_n = ren; ft_mode = ft; fifo_q = q;
    #1 chk("R8", {17'b0, fifo_re}, {17'b0, (c && !ren)});
    @(negedge rd_clk);
    m_rd = exp_rd(c, ren, ft, m_rp, m_e, m_f, q, m_rd);
    if (!c && !ren && !ft) m_rp = ~m_rp;
    cfg_n = 1; rd_en_n = 1; ft_mode = 0;
    chk(req, rd_data, m_rd);
  endtask

  task automatic finish_up();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    void'($urandom(32'd1234));
    m_e = 12'd127; m_f = 12'd127; m_wp = 0; m_rp = 0; m_rd = '0;
    #22;
    chk("R1", {6'b0, empty_ofs}, 18'd127);
    chk("R1", {6'b0, full_ofs}, 18'd127);
    chk("R1", rd_data, '0);
    @(negedge wr_clk); rst_n = 1;
    rcyc(0, 0, 0, '0, "R1");
    rcyc(0, 0, 0, '0, "R6");
    wcyc(0, 0, 18'h3F0A5, "R2");
    wcyc(1, 0, 18'h00777, "R4");
    wcyc(0, 0, 18'h00123, "R5");
    wcyc(0, 0, 18'h00456, "R3");
    rcyc(0, 0, 0, '0, "R6");
    rcyc(1, 0, 0, 18'h2ABCD, "R9");
    rcyc(0, 0, 1, 18'h11111, "R7");
    rcyc(0, 0, 0, '0, "R7");
    rcyc(0, 0, 0, '0, "R6");
    rcyc(1, 1, 0, 18'h12345, "R9");
    for (int i = 0; i < 300; i++) begin
      logic [2:0] op;
      logic [DW-1:0] d;
      op = 3'($urandom_range(0, 5));
      d = 18'($urandom);
      case (op)
        0: wcyc(0, 0, d, "R2");
        1: wcyc(1, 1'($urandom), d, "R4");
        2: rcyc(0, 0, 0, d, "R6");
        3: rcyc(0, 0, 1, d, "R7");
        4: rcyc(1, 0, 1'($urandom), d, "R9");
        default: wcyc(0, 1, d, "R5");
      endcase
    end
    finish_up();
  end
endmodule